// File: doc/BRIEF.md
# Host-port write sequencer

This block is a bus master that turns single write requests into byte-wide write cycles toward a DSP host port on a shared expansion bus. Each request carries an address, a data byte and five timing values. The access passes through five phases in a fixed order: address, data setup, strobe, hold and recovery. A phase programmed with the value N lasts N+1 clocks. Chip select and the address come up together. The active-low data strobe falls once the setup phase ends and rises when the strobe phase ends. Chip select drops after the hold phase. The recovery phase then keeps the bus idle before the next access can start. All counting is in bus clocks.

Requests enter through a valid/ready handshake. The block takes one request at a time. `req_ready` is high only while the sequencer is idle and recovery has finished. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid`, the address, the data and the timing inputs steady until that edge. After that edge the timing inputs may change freely, because the block keeps its own copy. The target's busy line `tgt_busy` is a plain level input. While it is high, the block cannot leave the address or strobe phase. After it falls, that phase lasts at least one more clock.

Top module: `hstrb_wr_seq`

## Requirements
- R1: Out of reset, `bus_cs_n` and `bus_strobe_n` are high, `bus_addr` and `bus_data` are zero, and `req_ready` is high.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` both high. From the next clock, `bus_cs_n` is low with the request's address on `bus_addr`, and `req_ready` is low. `req_ready` is never high while `bus_cs_n` is low.
- R3: With no stall, chip select is low for (A+1)+(S+1) clocks before the strobe falls. The strobe is then low for T+1 clocks, and chip select stays low for H+1 clocks after the strobe rises. A, S, T and H are the latched address, setup, strobe and hold values.
- R4: Address and setup values below 2, and a strobe value below 1, are raised to those floors. The hold and recovery values are used as given.
- R5: While chip select is low, `bus_addr` and `bus_data` hold the accepted request's address and data and do not change.
- R6: While chip select is high, `bus_addr` and `bus_data` are zero.
- R7: If the next request is already waiting, chip select stays high for R+2 clocks between two accesses, where R is the earlier access's recovery value.
- R8: If `tgt_busy` is high during the first K clocks of the address phase, that phase lasts max(A, K+1)+1 clocks.
- R9: If `tgt_busy` is high during the first K clocks of the strobe phase, the strobe stays low for max(T, K+1)+1 clocks.
- R10: `tgt_busy` during the hold phase has no effect: the hold still lasts H+1 clocks.
- R11: The five timing values are captured at acceptance. Changing the timing inputs later does not alter the access in progress.
- R12: The strobe is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | AW | Target address of the request |
| req_data | input | DW | Data byte of the request |
| cfg_addr_len | input | CFG_W | Address phase value |
| cfg_setup_len | input | CFG_W | Data setup phase value |
| cfg_strobe_len | input | CFG_W | Strobe phase value |
| cfg_hold_len | input | CFG_W | Hold phase value |
| cfg_recov_len | input | CFG_W | Recovery phase value |
| tgt_busy | input | 1 | Target stall, active high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_strobe_n | output | 1 | Write data strobe, active low |
| bus_addr | output | AW | Address lines |
| bus_data | output | DW | Data lines |

## Verification
The main function is exercised with several kinds of request:
- requests at the minimum timing values, the maximum values and mixed values, which separate the length of each phase from the others;
- values below the floors, which test the clamping;
- pairs and triples of back-to-back requests, which show the recovery gap and that nothing overlaps between accesses.

Stalls are applied at the start of the address phase and at the start of the strobe phase. Each is tested both longer and shorter than the programmed length, so the extra release clock is told apart from the programmed count. A stall during the hold phase shows that only the two stallable phases react. Every request scrambles the timing inputs and the request inputs right after acceptance, which shows that the access runs on its captured copy.

// File: rtl/hstrb_pkg.sv
`timescale 1ns/1ps
package hstrb_pkg;

  localparam int unsigned NPH = 5;

  localparam int unsigned IX_ADDR  = 0;
  localparam int unsigned IX_SETUP = 1;
  localparam int unsigned IX_STRB  = 2;
  localparam int unsigned IX_HOLD  = 3;
  localparam int unsigned IX_RECOV = 4;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SETUP = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5
  } hstrb_phase_e;

  // Lowest value each phase may run with; smaller programmed values are raised.
  function automatic int unsigned phase_floor(input int unsigned idx);
    case (idx)
      IX_ADDR:  return 2;
      IX_SETUP: return 2;
      IX_STRB:  return 1;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/hstrb_cfg_latch.sv
`timescale 1ns/1ps
// Captures the per-phase timing values at request acceptance, raised to floors.
module hstrb_cfg_latch
  import hstrb_pkg::*;
#(
  parameter int CFG_W = 4,
  parameter int N_PH  = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [N_PH-1:0][CFG_W-1:0]  cfg_raw,
  output logic [N_PH-1:0][CFG_W-1:0]  cfg_eff
);

  for (genvar gi = 0; gi < N_PH; gi++) begin : g_ph
    localparam logic [CFG_W-1:0] FLOOR = CFG_W'(phase_floor(gi));
    logic [CFG_W-1:0] clamped;
    logic [CFG_W-1:0] eff_q;

    assign clamped = (cfg_raw[gi] < FLOOR) ? FLOOR : cfg_raw[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        eff_q <= FLOOR;
      end else if (load) begin
        eff_q <= clamped;
      end
    end

    assign cfg_eff[gi] = eff_q;
  end

endmodule

// File: rtl/hstrb_phase_timer.sv
`timescale 1ns/1ps
// Counts clocks spent in the current phase; saturates so a long stall cannot wrap.
module hstrb_phase_timer #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CFG_W-1:0] limit,
  output logic             expired
);

  localparam logic [CFG_W-1:0] CNT_TOP = '1;
  localparam logic [CFG_W-1:0] CNT_ONE = CFG_W'(1);

  logic [CFG_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign expired = (cnt_q >= limit);

endmodule

// File: rtl/hstrb_stall_filter.sv
`timescale 1ns/1ps
// A stalled phase may end only when busy is low now and was low one clock ago.
module hstrb_stall_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  output logic clear
);

  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_in;
    end
  end

  assign clear = !busy_in && !busy_q;

endmodule

// File: rtl/hstrb_wr_seq.sv
`timescale 1ns/1ps
module hstrb_wr_seq
  import hstrb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  input  logic [CFG_W-1:0] cfg_addr_len,
  input  logic [CFG_W-1:0] cfg_setup_len,
  input  logic [CFG_W-1:0] cfg_strobe_len,
  input  logic [CFG_W-1:0] cfg_hold_len,
  input  logic [CFG_W-1:0] cfg_recov_len,
  input  logic             tgt_busy,
  output logic             bus_cs_n,
  output logic             bus_strobe_n,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_data
);

  hstrb_phase_e ph_q, ph_d;

  logic [NPH-1:0][CFG_W-1:0] cfg_raw;
  logic [NPH-1:0][CFG_W-1:0] cfg_eff;
  logic [CFG_W-1:0]          cur_lim;
  logic                      accept;
  logic                      tmr_done;
  logic                      stall_clear;
  logic                      in_access;
  logic [AW-1:0]             addr_q;
  logic [DW-1:0]             data_q;

  assign accept = req_valid && req_ready;

  assign cfg_raw[IX_ADDR]  = cfg_addr_len;
  assign cfg_raw[IX_SETUP] = cfg_setup_len;
  assign cfg_raw[IX_STRB]  = cfg_strobe_len;
  assign cfg_raw[IX_HOLD]  = cfg_hold_len;
  assign cfg_raw[IX_RECOV] = cfg_recov_len;

  hstrb_cfg_latch #(
    .CFG_W (CFG_W),
    .N_PH  (NPH)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .cfg_raw (cfg_raw),
    .cfg_eff (cfg_eff)
  );

  hstrb_phase_timer #(
    .CFG_W (CFG_W)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ph_d != ph_q),
    .limit   (cur_lim),
    .expired (tmr_done)
  );

  hstrb_stall_filter u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_in (tgt_busy),
    .clear   (stall_clear)
  );

  always_comb begin
    unique case (ph_q)
      PH_ADDR:  cur_lim = cfg_eff[IX_ADDR];
      PH_SETUP: cur_lim = cfg_eff[IX_SETUP];
      PH_STRB:  cur_lim = cfg_eff[IX_STRB];
      PH_HOLD:  cur_lim = cfg_eff[IX_HOLD];
      PH_RECOV: cur_lim = cfg_eff[IX_RECOV];
      default:  cur_lim = '0;
    endcase
  end

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (accept)                     ph_d = PH_ADDR;
      PH_ADDR:  if (tmr_done && stall_clear)    ph_d = PH_SETUP;
      PH_SETUP: if (tmr_done)                   ph_d = PH_STRB;
      PH_STRB:  if (tmr_done && stall_clear)    ph_d = PH_HOLD;
      PH_HOLD:  if (tmr_done)                   ph_d = PH_RECOV;
      PH_RECOV: if (tmr_done)                   ph_d = PH_IDLE;
      default:                                  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  assign in_access    = (ph_q == PH_ADDR) || (ph_q == PH_SETUP) ||
                        (ph_q == PH_STRB) || (ph_q == PH_HOLD);
  assign req_ready    = (ph_q == PH_IDLE);
  assign bus_cs_n     = !in_access;
  assign bus_strobe_n = (ph_q != PH_STRB);
  assign bus_addr     = in_access ? addr_q : '0;
  assign bus_data     = in_access ? data_q : '0;

endmodule

// File: rtl/hstrb_wr_seq_chk.sv
`timescale 1ns/1ps
module hstrb_wr_seq_chk
  import hstrb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          tgt_busy,
  input logic          bus_cs_n,
  input logic          bus_strobe_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data,
  input hstrb_phase_e  ph_q
);

  AST_STRB_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe_n |-> !bus_cs_n); // R12

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_data))); // R5

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> (bus_addr == '0 && bus_data == '0)); // R6

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ph_q == PH_ADDR && !bus_cs_n && !req_ready)); // R2

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n); // R2

  AST_ADDR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR && tgt_busy) |=> (ph_q == PH_ADDR)); // R8

  AST_ADDR_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR && $fell(tgt_busy)) |=> (ph_q == PH_ADDR)); // R8

  AST_STRB_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strobe_n && tgt_busy) |=> !bus_strobe_n); // R9

  AST_STRB_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strobe_n && $fell(tgt_busy)) |=> !bus_strobe_n); // R9

  AST_STRB_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strobe_n) |-> !$past(bus_strobe_n, 2)); // R4

endmodule

bind hstrb_wr_seq hstrb_wr_seq_chk #(
  .AW (AW),
  .DW (DW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .tgt_busy     (tgt_busy),
  .bus_cs_n     (bus_cs_n),
  .bus_strobe_n (bus_strobe_n),
  .bus_addr     (bus_addr),
  .bus_data     (bus_data),
  .ph_q         (ph_q)
);

// File: tb/hstrb_wr_seq_tb_top.sv
`timescale 1ns/1ps
module hstrb_wr_seq_tb_top;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] c_addr = '0, c_setup = '0, c_strb = '0, c_hold = '0, c_recov = '0;
  logic          tgt_busy = 1'b0;
  logic          bus_cs_n, bus_strobe_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  always #2.5 clk = ~clk;

  hstrb_wr_seq #(.AW(AW), .DW(DW), .CFG_W(CW)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_data (req_data),
    .cfg_addr_len (c_addr), .cfg_setup_len (c_setup), .cfg_strobe_len (c_strb),
    .cfg_hold_len (c_hold), .cfg_recov_len (c_recov),
    .tgt_busy (tgt_busy),
    .bus_cs_n (bus_cs_n), .bus_strobe_n (bus_strobe_n),
    .bus_addr (bus_addr), .bus_data (bus_data)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            pre;
    int            stb;
    int            post;
    int            gap;
    string         tag;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    prev_recov = 0;
  int    stall_mode = 0;   // 0 none, 1 address phase, 3 strobe phase, 4 hold phase
  int    stall_len = 0;
  bit    strb_out_seen = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int floor_of(input int raw, input int fl);
    return (raw < fl) ? fl : raw;
  endfunction

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // Driver: computes the expected access, queues it, then performs the handshake.
  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int c1, input int c2, input int c3, input int c4, input int c5,
                      input int smode, input int slen, input bit b2b, input string tag);
    exp_t e;
    int e1, e2, e3, e4, e5;
    e1 = floor_of(c1, 2);
    e2 = floor_of(c2, 2);
    e3 = floor_of(c3, 1);
    e4 = c4;
    e5 = c5;
    e.a    = a;
    e.d    = d;
    e.pre  = ((smode == 1) ? imax(e1, slen + 1) + 1 : e1 + 1) + e2 + 1;
    e.stb  = (smode == 3) ? imax(e3, slen + 1) + 1 : e3 + 1;
    e.post = e4 + 1;
    e.gap  = b2b ? prev_recov + 2 : -1;
    e.tag  = tag;
    prev_recov = e5;
    exp_q.push_back(e);
    @(negedge clk);
    if (smode != 0) begin
      stall_mode = smode;
      stall_len  = slen;
    end
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    c_addr  = CW'(c1);
    c_setup = CW'(c2);
    c_strb  = CW'(c3);
    c_hold  = CW'(c4);
    c_recov = CW'(c5);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2", "req_ready after accept", int'(req_ready), 0);
    check(bus_cs_n == 1'b0, "R2", "bus_cs_n after accept", int'(bus_cs_n), 0);
    check(bus_addr == a, "R2", "bus_addr after accept", int'(bus_addr), int'(a));
    // R11: scramble the request and timing inputs while the access runs
    req_addr = ~a;
    req_data = ~d;
    c_addr = '1; c_setup = '1; c_strb = '1; c_hold = '1; c_recov = '1;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // Stall generator: raises tgt_busy on the first clock of the selected phase.
  initial begin : stall_gen
    logic pcs, pstb;
    pcs = 1'b1;
    pstb = 1'b1;
    forever begin
      @(negedge clk);
      if ((stall_mode == 1 && pcs && !bus_cs_n) ||
          (stall_mode == 3 && pstb && !bus_strobe_n) ||
          (stall_mode == 4 && !pstb && bus_strobe_n)) begin
        tgt_busy = 1'b1;
        repeat (stall_len) @(negedge clk);
        tgt_busy = 1'b0;
        stall_mode = 0;
      end
      pcs  = bus_cs_n;
      pstb = bus_strobe_n;
    end
  end

  // Monitor: rebuilds each access from the bus and compares with the queue.
  initial begin : monitor
    int pre, stb, post, gap, gap_seen;
    bit in_acc, seen_stb, unstable, idle_bad;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    exp_t e;
    pre = 0; stb = 0; post = 0; gap = 0; gap_seen = 0;
    in_acc = 0; seen_stb = 0; unstable = 0; idle_bad = 0;
    a0 = '0; d0 = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (bus_cs_n && !bus_strobe_n) strb_out_seen = 1'b1;
        if (!bus_cs_n) begin
          if (!in_acc) begin
            in_acc = 1; pre = 0; stb = 0; post = 0; seen_stb = 0; unstable = 0;
            a0 = bus_addr; d0 = bus_data; gap_seen = gap;
          end
          if (bus_addr != a0 || bus_data != d0) unstable = 1;
          if (!bus_strobe_n) begin
            stb++;
            seen_stb = 1;
          end else if (seen_stb) begin
            post++;
          end else begin
            pre++;
          end
        end else begin
          if (in_acc) begin
            in_acc = 0;
            if (exp_q.size() == 0) begin
              check(1'b0, "R2", "unexpected access", 1, 0);
            end else begin
              e = exp_q.pop_front();
              check(a0 == e.a, "R5", {e.tag, " address"}, int'(a0), int'(e.a));
              check(d0 == e.d, "R5", {e.tag, " data"}, int'(d0), int'(e.d));
              check(!unstable, "R5", {e.tag, " bus stable"}, int'(unstable), 0);
              check(pre == e.pre, e.tag, "clocks before strobe", pre, e.pre);
              check(stb == e.stb, e.tag, "strobe clocks", stb, e.stb);
              check(post == e.post, (e.tag == "R10") ? "R10" : "R3",
                    "hold clocks", post, e.post);
              if (e.gap >= 0)
                check(gap_seen == e.gap, "R7", "recovery gap", gap_seen, e.gap);
              check(!idle_bad, "R6", "idle bus value", int'(idle_bad), 0);
            end
            gap = 0;
            idle_bad = 0;
          end
          gap++;
          if (bus_addr != '0 || bus_data != '0) idle_bad = 1;
        end
      end
    end
  end

  task automatic run_tests();
    repeat (5) @(negedge clk);
    check(bus_cs_n == 1'b1, "R1", "cs in reset", int'(bus_cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_cs_n == 1'b1, "R1", "cs after reset", int'(bus_cs_n), 1);
    check(bus_strobe_n == 1'b1, "R1", "strobe after reset", int'(bus_strobe_n), 1);
    check(bus_addr == '0 && bus_data == '0, "R1", "bus after reset",
          int'(bus_addr) + int'(bus_data), 0);
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

    // R3: minimum legal timing
    send(16'h1234, 8'hA5, 2, 2, 1, 0, 0, 0, 0, 1'b0, "R3");
    wait_done();
    // R3 / R7: back-to-back accesses with mixed timing
    send(16'h0F0F, 8'h3C, 5, 3, 4, 2, 3, 0, 0, 1'b0, "R3");
    send(16'hF00F, 8'hC3, 2, 4, 2, 1, 2, 0, 0, 1'b1, "R7");
    send(16'hBEEF, 8'h01, 3, 2, 1, 3, 0, 0, 0, 1'b1, "R7");
    wait_done();
    // R4: values below the floors
    send(16'h0001, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 1'b0, "R4");
    wait_done();
    send(16'h0002, 8'h7E, 1, 1, 0, 0, 1, 0, 0, 1'b0, "R4");
    wait_done();
    // R3: maximum timing
    send(16'hFFFF, 8'h80, 15, 15, 15, 15, 15, 0, 0, 1'b0, "R3");
    wait_done();
    // R8: address-phase stall longer and shorter than the programmed phase
    send(16'h2222, 8'h22, 2, 2, 1, 1, 1, 1, 6, 1'b0, "R8");
    wait_done();
    send(16'h3333, 8'h33, 8, 2, 1, 1, 1, 1, 2, 1'b0, "R8");
    wait_done();
    // R9: strobe-phase stall longer and shorter than the programmed phase
    send(16'h4444, 8'h44, 2, 2, 1, 1, 1, 3, 5, 1'b0, "R9");
    wait_done();
    send(16'h5555, 8'h55, 2, 2, 6, 1, 1, 3, 3, 1'b0, "R9");
    wait_done();
    // R10: stall during hold is ignored
    send(16'h6666, 8'h66, 2, 2, 1, 1, 3, 4, 3, 1'b0, "R10");
    wait_done();
    // R11: timing inputs scrambled right after acceptance
    send(16'h7777, 8'h77, 3, 3, 2, 2, 2, 0, 0, 1'b0, "R11");
    send(16'h8888, 8'h88, 2, 2, 1, 0, 1, 0, 0, 1'b1, "R11");
    wait_done();
    check(!strb_out_seen, "R12", "strobe outside chip select", int'(strb_out_seen), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule